// File: doc/BRIEF.md
# Byte-Wide SPI Master with Completion Flag

This block is a full-duplex SPI master that moves one byte per transfer and has no transmit buffer. Writing a byte to the data register loads the shifter directly and starts the transfer in the next cycle. Eight serial clock periods follow. In each period the master drives one bit on `mosi` and captures one bit from `miso` into the same register. When the eighth bit is done, a completion flag is set and, if enabled, an interrupt is raised. Software must clear the flag before the block accepts another byte. If software writes a byte while the flag is still set, or while a shift is running, the write is discarded and a collision bit is recorded.

The serial clock is fixed to SPI mode 0: the clock idles low, the slave samples on the rising edge, and data changes on the falling edge. Bits go out most significant first. The clock rate is the system clock divided by an even number from 2 to 256, set in the control register. A select register drives one active-low chip-select line per slave. Software sets these lines before it starts a transfer.

The host interface is a simple register port with a write strobe, a 2-bit address, write data and combinational read data. The register addresses are: 0 data, 1 control, 2 status, 3 select.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, `cs_n` is all ones, `sck` is low, `irq` is low, and the status register reads zero.
- R2: A write to address 0 while the block is idle and the completion flag is clear loads the byte and sets busy (status bit 2) at the very next clock edge. The byte is sent on `mosi` most significant bit first.
- R3: The control register bits [6:0] hold a value H. The serial clock then has a period of 2·(H+1) system clocks, and busy stays high for exactly 16·(H+1) cycles per transfer.
- R4: `sck` is low whenever no transfer is running. During a transfer, `mosi` changes only in the cycle in which `sck` falls.
- R5: `miso` is sampled on each rising edge of `sck`, most significant bit first. When the transfer ends, a read of address 0 returns the received byte.
- R6: The completion flag (status bit 0) is set in the same cycle in which busy falls at the end of a transfer.
- R7: `irq` is high exactly when the completion flag is set and the enable bit (control bit 7) is 1.
- R8: A write to address 0 while the completion flag or busy is set starts no transfer and leaves the data register unchanged. It sets the collision bit (status bit 1).
- R9: Writing 1 to status bit 0 or bit 1 clears that bit. Writing 0 to either bit leaves it unchanged.
- R10: The select register (address 3) drives `cs_n` bit for bit. A line stays unchanged until that register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Completion interrupt |
| sck | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low slave selects |

## Verification
The hardest case to reach is a data write that arrives while a shift is already running. The busy window is only 16·(H+1) cycles long, and the flag is still clear during it. The stimulus sets a large divider, starts a byte, and writes a second byte a few cycles later. The bench slave then checks that the original byte arrived intact, and the status read confirms that the collision bit is set and the received byte is correct. A separate case writes while the flag is set. It confirms that no clock edge follows and that the data register keeps the previous received byte.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;
   typedef enum logic [1:0] {
      REG_DATA = 2'd0,
      REG_CTRL = 2'd1,
      REG_STAT = 2'd2,
      REG_SEL  = 2'd3
   } reg_addr_e;

   localparam int STAT_FLAG = 0;
   localparam int STAT_COL  = 1;
   localparam int STAT_BUSY = 2;
endpackage

// File: rtl/spi_sck_div.sv
module spi_sck_div #(
   parameter int DIV_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q == half);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (!run)      cnt_q <= '0;
      else if (tick)      cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] load,
   input  logic              tick,
   input  logic              miso,
   output logic              busy,
   output logic              sck,
   output logic              mosi,
   output logic              done,
   output logic [DATA_W-1:0] shreg
);
   localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic [CNT_W-1:0] bit_q;
   logic             samp_q;

   assign mosi = shreg[DATA_W-1];
   assign done = tick && sck && (bit_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         sck    <= 1'b0;
         bit_q  <= '0;
         samp_q <= 1'b0;
         shreg  <= '0;
      end else if (start) begin
         busy   <= 1'b1;
         sck    <= 1'b0;
         bit_q  <= '0;
         shreg  <= load;
      end else if (tick) begin
         if (!sck) begin
            sck    <= 1'b1;
            samp_q <= miso;
         end else begin
            sck   <= 1'b0;
            shreg <= {shreg[DATA_W-2:0], samp_q};
            if (bit_q == LAST) busy <= 1'b0;
            else               bit_q <= bit_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
   parameter int DATA_W  = 8,
   parameter int DIV_W   = 7,
   parameter int NUM_SEL = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq,
   output logic              sck,
   output logic              mosi,
   input  logic              miso,
   output logic [NUM_SEL-1:0] cs_n
);
   import spi_byte_pkg::*;

   localparam int IEN_BIT = DATA_W - 1;

   generate
      if (DATA_W < 4)            begin : g_bad_w   $error("DATA_W must be at least 4"); end
      if (DIV_W < 1 || DIV_W > DATA_W - 1) begin : g_bad_div $error("DIV_W out of range"); end
      if (NUM_SEL < 1 || NUM_SEL > DATA_W) begin : g_bad_sel $error("NUM_SEL out of range"); end
   endgenerate

   logic [DIV_W-1:0]  half_q;
   logic              ien_q;
   logic              flag_q;
   logic              col_q;
   logic [NUM_SEL-1:0] sel_q;

   logic              busy_w, done_w, tick_w;
   logic [DATA_W-1:0] shreg_w;

   logic wr_data, wr_ctrl, wr_stat, wr_sel, start_w, coll_w;

   assign wr_data = wr_en && (addr == REG_DATA);
   assign wr_ctrl = wr_en && (addr == REG_CTRL);
   assign wr_stat = wr_en && (addr == REG_STAT);
   assign wr_sel  = wr_en && (addr == REG_SEL);
   assign start_w = wr_data && !busy_w && !flag_q;
   assign coll_w  = wr_data && (busy_w || flag_q);

   spi_sck_div #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(busy_w), .half(half_q), .tick(tick_w)
   );

   spi_shift_eng #(.DATA_W(DATA_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(start_w), .load(wdata), .tick(tick_w),
      .miso(miso), .busy(busy_w), .sck(sck), .mosi(mosi), .done(done_w),
      .shreg(shreg_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q <= '0;
         ien_q  <= 1'b0;
      end else if (wr_ctrl) begin
         half_q <= wdata[DIV_W-1:0];
         ien_q  <= wdata[IEN_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         col_q  <= 1'b0;
      end else begin
         if (done_w)                        flag_q <= 1'b1;
         else if (wr_stat && wdata[STAT_FLAG]) flag_q <= 1'b0;
         if (coll_w)                        col_q <= 1'b1;
         else if (wr_stat && wdata[STAT_COL])  col_q <= 1'b0;
      end
   end

   generate
      for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sel_q[i] <= 1'b1;
            else if (wr_sel) sel_q[i] <= wdata[i];
         end
         assign cs_n[i] = sel_q[i];
      end
   endgenerate

   always_comb begin
      rdata = '0;
      unique case (addr)
         REG_DATA: rdata = shreg_w;
         REG_CTRL: begin
            rdata[DIV_W-1:0] = half_q;
            rdata[IEN_BIT]   = ien_q;
         end
         REG_STAT: begin
            rdata[STAT_FLAG] = flag_q;
            rdata[STAT_COL]  = col_q;
            rdata[STAT_BUSY] = busy_w;
         end
         default:  rdata[NUM_SEL-1:0] = sel_q;
      endcase
   end

   assign irq = flag_q && ien_q;
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk #(
   parameter int NUM_SEL = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [1:0]         addr,
   input logic               sck,
   input logic               mosi,
   input logic               irq,
   input logic               busy,
   input logic               flag,
   input logic [NUM_SEL-1:0] cs_n
);
   p_idle_sck_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sck);

   p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$fell(sck)) |-> $stable(mosi));

   p_flag_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> flag);

   p_no_shift_with_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(flag && busy));

   p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flag);

   p_cs_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en && addr == 2'd3) |-> $stable(cs_n));
endmodule

bind spi_byte_master spi_byte_master_chk #(.NUM_SEL(NUM_SEL)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .sck(sck),
   .mosi(mosi), .irq(irq), .busy(busy_w), .flag(flag_q), .cs_n(cs_n)
);

// File: tb/spi_byte_master_test.sv
module spi_byte_master_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       irq, sck, mosi;
   logic       miso = 1'b0;
   logic [3:0] cs_n;

   int tests = 0;
   int fails = 0;
   bit finished = 0;

   byte unsigned exp_q[$];
   logic [7:0] s_tx = 8'h00;
   logic [7:0] s_cap = 8'h00;
   int         s_n = 8;

   always #4 clk = ~clk;

   spi_byte_master uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .irq(irq), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // slave model + monitor: captures mosi on rising sck, compares with queue
   always @(posedge sck) begin
      s_cap = {s_cap[6:0], mosi};
      s_n++;
      if (s_n == 8) begin
         if (exp_q.size() == 0) chk(0, "R2 unexpected frame", s_cap, 0);
         else begin
            byte unsigned e;
            e = exp_q.pop_front();
            chk(s_cap == e, "R2 mosi byte", s_cap, e);
         end
      end
   end
   always @(negedge sck) if (s_n < 8) miso = s_tx[7 - s_n];

   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic xfer_start(input logic [7:0] tx, input logic [7:0] srx);
      s_tx = srx; s_n = 0; miso = srx[7];
      exp_q.push_back(tx);
      bus_wr(2'd0, tx);
   endtask

   task automatic wait_idle(output int cycles);
      cycles = 0;
      addr = 2'd2;
      #1;
      while (rdata[2]) begin
         cycles++;
         @(negedge clk);
         addr = 2'd2;
         #1;
      end
   endtask

   task automatic xfer(input logic [7:0] tx, input logic [7:0] srx, input int h);
      int cyc;
      logic [7:0] d;
      xfer_start(tx, srx);
      wait_idle(cyc);
      chk(cyc == 16 * (h + 1), "R3 busy length", cyc, 16 * (h + 1));
      bus_rd(2'd2, d);
      chk(d[0] == 1'b1, "R6 flag set", d, 1);
      bus_rd(2'd0, d);
      chk(d == srx, "R5 rx byte", d, srx);
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         fails++; tests++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      int cyc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      bus_rd(2'd2, d);
      chk(d == 8'h00, "R1 status", d, 0);
      chk(cs_n == 4'hF, "R1 cs_n", cs_n, 4'hF);
      chk(sck == 1'b0 && irq == 1'b0, "R1 sck/irq", {sck, irq}, 0);

      // R10 select register
      bus_wr(2'd3, 8'h0E);
      chk(cs_n == 4'hE, "R10 select slave 0", cs_n, 4'hE);

      // fastest divisor, irq enabled
      bus_wr(2'd1, 8'h80);
      @(negedge clk);
      chk(sck == 1'b0, "R4 idle sck", sck, 0);
      xfer(8'hA5, 8'h3C, 0);
      chk(irq == 1'b1, "R7 irq with enable", irq, 1);

      // R8 write while flag set
      bus_wr(2'd0, 8'h55);
      repeat (20) @(negedge clk);
      chk(s_n == 8, "R8 no clock after collided write", s_n, 8);
      bus_rd(2'd2, d);
      chk(d == 8'h03, "R8 collision and flag", d, 8'h03);
      bus_rd(2'd0, d);
      chk(d == 8'h3C, "R8 data unchanged", d, 8'h3C);

      // R9 writing zeros has no effect, ones clear
      bus_wr(2'd2, 8'h00);
      bus_rd(2'd2, d);
      chk(d == 8'h03, "R9 zero write ignored", d, 8'h03);
      bus_wr(2'd2, 8'h01);
      bus_rd(2'd2, d);
      chk(d == 8'h02, "R9 clear flag only", d, 8'h02);
      chk(irq == 1'b0, "R7 irq drops with flag", irq, 0);
      bus_wr(2'd2, 8'h02);
      bus_rd(2'd2, d);
      chk(d == 8'h00, "R9 clear collision", d, 0);

      // divisor 6, irq disabled
      bus_wr(2'd1, 8'h02);
      xfer(8'h81, 8'h7E, 2);
      chk(irq == 1'b0, "R7 irq masked", irq, 0);
      bus_wr(2'd2, 8'h01);

      // R8 write during busy
      bus_wr(2'd1, 8'h03);
      xfer_start(8'hC3, 8'h96);
      repeat (5) @(negedge clk);
      bus_wr(2'd0, 8'hFF);
      wait_idle(cyc);
      bus_rd(2'd2, d);
      chk(d == 8'h03, "R8 collision during busy", d, 8'h03);
      bus_rd(2'd0, d);
      chk(d == 8'h96, "R8 rx intact after busy write", d, 8'h96);
      bus_wr(2'd2, 8'h03);

      // slowest divisor
      bus_wr(2'd1, 8'h7F);
      xfer(8'h01, 8'hFE, 127);
      bus_wr(2'd2, 8'h01);

      // R10 change select
      bus_wr(2'd3, 8'h07);
      chk(cs_n == 4'h7, "R10 select slave 3", cs_n, 4'h7);
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R2 all frames seen", exp_q.size(), 0);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule